// File: doc/BRIEF.md
# Saturating Float-to-Fixed Vector Converter

This block takes a 128-bit vector of four IEEE-754 single-precision values and turns each one into a signed 32-bit fixed-point word. A 5-bit scale immediate sets the number of fractional bits of the result. Each lane is multiplied by two to the power of that immediate and then truncated toward zero. A lane that does not fit in 32 signed bits is clamped to the nearest rail instead of wrapping.

The block sits in a vector execution pipe and has one register stage. A valid strobe goes in with each operand, and a matching strobe comes out one clock later with the result. A sticky saturation flag gathers overflow, infinity and NaN events from all lanes. The flag stays set until a separate clear input resets it. A flush control bit forces denormal inputs to zero before scaling.

Top module: `f2q_vec_conv`

## Requirements
- R1: Lane 0 occupies bits 127:96 of the source and of the result, lane 3 occupies bits 31:0, and each lane is converted on its own.
- R2: For a finite input, each lane's result is value × 2^scale_imm (scale_imm from 0 to 31) truncated toward zero. This holds for both signs: 2.75 → 2, −1.5 → −1.
- R3: A finite lane whose scaled value is at least 2^31, or below −2^31, produces 0x7FFFFFFF if positive or 0x80000000 if negative, and counts as a saturation event.
- R4: A lane whose scaled value is exactly −2^31 produces 0x80000000 and is not a saturation event.
- R5: A NaN lane (exponent all ones, non-zero fraction) produces 0 and counts as a saturation event.
- R6: +infinity produces 0x7FFFFFFF and −infinity produces 0x80000000, and both count as saturation events.
- R7: A lane whose scaled magnitude is below 1.0, including every denormal input with flush_den set or clear, produces 0 and is not a saturation event.
- R8: out_vld equals in_vld one clock earlier. res_vec loads on the edge that accepts a valid input and holds its value otherwise.
- R9: sat_sticky is set on the edge after a valid input in which any lane saturates. It stays set while sat_clr is low.
- R10: sat_clr resets sat_sticky on the next edge. If a saturation event comes in the same cycle, the event wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Source operand valid |
| src_vec | input | 128 | Four single-precision lanes, lane 0 in the top word |
| scale_imm | input | 5 | Number of fractional bits of the result |
| flush_den | input | 1 | Flush denormal inputs to zero |
| sat_clr | input | 1 | Clear request for the sticky saturation flag |
| out_vld | output | 1 | Result valid, one clock after in_vld |
| res_vec | output | 128 | Four signed 32-bit fixed-point lanes |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
The embedded assertions check on every cycle:
- the one-clock valid latency and the holding of res_vec between valid inputs;
- that any saturating non-NaN lane produces exactly one of the two rails;
- the set, hold and clear behaviour of the sticky flag, including a clear that arrives together with a new event.

Only the bench's scenarios can show that the values are numerically correct. A scoreboard compares each lane against an independent shift-based model. The scenarios cover:
- truncation of positive and negative fractions across several scale values;
- lane ordering;
- the exact −2^31 case that must not saturate;
- NaN, infinities and denormals under both flush settings.

// File: rtl/f2q_pkg.sv
package f2q_pkg;
  localparam int unsigned FP_W   = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned SH_W   = 5;
  localparam int signed   BIAS   = 127;
  localparam logic [FP_W-1:0] Q_MAX = 32'h7FFF_FFFF;
  localparam logic [FP_W-1:0] Q_MIN = 32'h8000_0000;

  typedef struct packed {
    logic [FP_W-1:0] val;
    logic            sat;
    logic            nan;
  } lane_res_t;

  // Scaling is an exponent add; the significand is then shifted into place.
  function automatic lane_res_t f2q_cvt(input logic [FP_W-1:0] f,
                                        input logic [SH_W-1:0] sh,
                                        input logic            nj);
    lane_res_t       r;
    logic            sgn;
    logic [EXP_W-1:0] ex;
    logic [FRAC_W-1:0] fr;
    logic [FRAC_W:0]  sig;
    logic signed [9:0] e;
    logic [4:0]       amt;
    logic [FP_W-1:0]  mag;
    sgn = f[FP_W-1];
    ex  = f[FP_W-2:FRAC_W];
    fr  = f[FRAC_W-1:0];
    sig = {(ex != '0), fr};
    e   = (ex == '0 ? 10'sd1 : signed'({2'b00, ex})) - 10'(BIAS)
          + signed'({5'b00000, sh});
    r   = '0;
    amt = '0;
    mag = '0;
    if (ex == '1) begin
      r.sat = 1'b1;
      if (fr != '0) r.nan = 1'b1;
      else          r.val = sgn ? Q_MIN : Q_MAX;
    end else if ((ex == '0 && nj) || sig == '0 || e < 0) begin
      r.val = '0;
    end else if (e >= 10'sd31) begin
      if (sgn && e == 10'sd31 && fr == '0) r.val = Q_MIN;
      else begin
        r.sat = 1'b1;
        r.val = sgn ? Q_MIN : Q_MAX;
      end
    end else begin
      if (e >= 10'sd23) begin
        amt = e[4:0] - 5'd23;
        mag = {8'b0, sig} << amt;
      end else begin
        amt = 5'd23 - e[4:0];
        mag = {8'b0, sig} >> amt;
      end
      r.val = sgn ? (~mag + 32'd1) : mag;
    end
    return r;
  endfunction
endpackage

// File: rtl/f2q_lane.sv
module f2q_lane
  import f2q_pkg::*;
(
  input  logic [FP_W-1:0] f_i,
  input  logic [SH_W-1:0] sh_i,
  input  logic            nj_i,
  output logic [FP_W-1:0] q_o,
  output logic            sat_o
);
  lane_res_t res;
  logic      nan_w;

  always_comb begin
    res   = f2q_cvt(f_i, sh_i, nj_i);
    q_o   = res.val;
    sat_o = res.sat;
    nan_w = res.nan;
  end

  // A saturating, non-NaN lane must land on one of the two rails, matching sign
  always_comb begin
    if (sat_o && !nan_w)
      assert_rail_value_R3: assert ((f_i[FP_W-1] && q_o == Q_MIN) ||
                                    (!f_i[FP_W-1] && q_o == Q_MAX));
  end
endmodule

// File: rtl/f2q_sticky.sv
module f2q_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic stk_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     stk_o <= 1'b0;
    else if (set_i) stk_o <= 1'b1;
    else if (clr_i) stk_o <= 1'b0;
  end

  assert_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> stk_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_o && !clr_i) |=> stk_o);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !stk_o);
endmodule

// File: rtl/f2q_vec_conv.sv
module f2q_vec_conv
  import f2q_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic [LANES*FP_W-1:0] src_vec,
  input  logic [SH_W-1:0]       scale_imm,
  input  logic                  flush_den,
  input  logic                  sat_clr,
  output logic                  out_vld,
  output logic [LANES*FP_W-1:0] res_vec,
  output logic                  sat_sticky
);
  localparam int unsigned VEC_W = LANES * FP_W;

  logic [VEC_W-1:0] q_w;
  logic [LANES-1:0] lane_sat;
  logic             sat_event;

  // Lane 0 is the most significant word
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned HI = VEC_W - 1 - i * FP_W;
    f2q_lane u_lane (
      .f_i  (src_vec[HI -: FP_W]),
      .sh_i (scale_imm),
      .nj_i (flush_den),
      .q_o  (q_w[HI -: FP_W]),
      .sat_o(lane_sat[i])
    );
  end

  assign sat_event = in_vld && (|lane_sat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      res_vec <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) res_vec <= q_w;
    end
  end

  f2q_sticky u_sticky (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(sat_event),
    .clr_i(sat_clr),
    .stk_o(sat_sticky)
  );

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(res_vec)));
endmodule

// File: tb/tb_f2q_vec_conv.sv
module tb_f2q_vec_conv;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [127:0] src_vec = '0;
  logic [4:0]   scale_imm = '0;
  logic         flush_den = 1'b0;
  logic         sat_clr = 1'b0;
  logic         out_vld;
  logic [127:0] res_vec;
  logic         sat_sticky;

  always #5 clk = ~clk;

  f2q_vec_conv dut (.*);

  typedef struct {
    logic         vld;
    logic [127:0] res;
    logic         stk;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           n_run = 0;
  int           n_fail = 0;
  logic         m_stk = 1'b0;
  logic [127:0] m_res = '0;
  bit           drained = 0;

  function automatic void ref_cvt(input logic [31:0] f, input int imm,
                                  output logic [31:0] q, output bit s);
    int     ex;
    int     sh;
    longint m;
    ex = int'(f[30:23]);
    s = 0;
    q = '0;
    if (ex == 255) begin
      s = 1;
      if (f[22:0] == 0) q = f[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      return;
    end
    if (ex == 0) return;
    m  = longint'({1'b1, f[22:0]});
    sh = ex - 150 + imm;
    if (sh > 8)        m = 64'h1_0000_0000;
    else if (sh >= 0)  m = m << sh;
    else if (sh < -24) m = 0;
    else               m = m >>> (-sh);
    if (f[31]) begin
      if (m > 64'h8000_0000) begin s = 1; q = 32'h8000_0000; end
      else q = 32'(-m);
    end else begin
      if (m > 64'h7FFF_FFFF) begin s = 1; q = 32'h7FFF_FFFF; end
      else q = 32'(m);
    end
  endfunction

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic vld, input logic [127:0] v,
                       input int imm, input logic nj, input logic clr,
                       input string tag);
    exp_t        e;
    logic [31:0] q;
    bit          s;
    bit          any = 0;
    @(negedge clk);
    in_vld = vld; src_vec = v; scale_imm = 5'(imm);
    flush_den = nj; sat_clr = clr;
    if (vld) begin
      for (int i = 0; i < 4; i++) begin
        ref_cvt(v[127 - 32*i -: 32], imm, q, s);
        m_res[127 - 32*i -: 32] = q;
        any |= s;
      end
    end
    if (vld && any) m_stk = 1'b1;
    else if (clr)   m_stk = 1'b0;
    e.vld = vld; e.res = m_res; e.stk = m_stk; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares each cycle's outputs shortly after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({e.tag, " vld"}, 128'(out_vld), 128'(e.vld));
        check({e.tag, " res"}, res_vec, e.res);
        check({e.tag, " stk"}, 128'(sat_sticky), 128'(e.stk));
      end
    end
  end

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset out_vld", 128'(out_vld), 128'(0));
    check("reset res_vec", res_vec, '0);
    check("reset sat_sticky", 128'(sat_sticky), 128'(0));
    rst_n = 1'b1;
    // R1 R2: {1.0, -1.5, 2.75, 0.5} at two scales
    drive(1, {32'h3F80_0000, 32'hBFC0_0000, 32'h4030_0000, 32'h3F00_0000}, 0, 0, 0, "R1_R2 imm0");
    drive(1, {32'h3F80_0000, 32'hBFC0_0000, 32'h4030_0000, 32'h3F00_0000}, 4, 0, 0, "R2 imm4");
    drive(1, {32'h3F00_0000, 32'hBF40_0000, 32'h4030_0000, 32'hBF80_0000}, 31, 0, 0, "R2_R4 imm31");
    drive(1, {32'h3F00_0000, 32'h3F80_0000, 32'h4030_0000, 32'h3FC0_0000}, 7, 0, 0, "R1 lanes");
    // R3 overflow both signs
    drive(1, {32'h3F80_0000, 32'h0000_0000, 32'hC000_0000, 32'h3F00_0000}, 31, 0, 0, "R3 overflow");
    drive(0, {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000}, 0, 0, 0, "R8 R9 idle hold");
    drive(1, {32'h4F00_0000, 32'hCF00_0001, 32'h0, 32'h0}, 0, 0, 0, "R3 boundary");
    drive(0, '0, 0, 0, 1, "R10 clear");
    drive(1, {32'hCF00_0000, 32'h0, 32'h0, 32'h0}, 0, 0, 0, "R4 exact min");
    drive(1, {32'h3F80_0000, 32'h7FC0_0000, 32'h3F80_0000, 32'h4000_0000}, 2, 0, 0, "R5 nan");
    drive(1, {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000}, 1, 0, 0, "R9 sticky holds");
    drive(1, {32'h7F80_0000, 32'hFF80_0000, 32'h3F80_0000, 32'h0}, 3, 0, 1, "R6_R10 inf with clear");
    drive(0, '0, 0, 0, 1, "R10 clear");
    drive(1, {32'h0000_0001, 32'h807F_FFFF, 32'h3F00_0000, 32'hBF00_0000}, 0, 0, 0, "R7 tiny nj0");
    drive(1, {32'h0000_0001, 32'h807F_FFFF, 32'h3E80_0000, 32'hBE80_0000}, 31, 1, 0, "R7 tiny nj1");
    drive(0, '0, 0, 0, 0, "R8 drain");
    repeat (3) @(negedge clk);
    drained = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule